// File: doc/BRIEF.md
# Dual-Clock Width-Matching FIFO with Mark and Retransmit

This block is a first-in first-out buffer between two unrelated clock domains. The writer and the reader each have their own clock, an enable and a chip select, and they may run at the same time. At master reset the block latches a port-width pairing. In a narrow-to-wide pairing it gathers several input slices into one stored word. In a wide-to-narrow pairing it hands one stored word to the reader as several slices. Storage is always one full-width word per location.

Two read timing modes are available, also latched at master reset. In standard mode the flags report empty and full, and a read loads the output register. In fall-through mode the flags report output-ready and input-ready, and the head word is presented on the output without any read request. The reader can mark the word at the head and later return the read position to it. While a mark is held, the locations from the mark onward are protected from being overwritten. A partial reset empties the buffer and keeps the latched pairing and timing mode.

Top module: `wmfifo`

## Requirements
- R1: While master reset is high, `bus_cfg` and `fwft_en` are captured. After reset in standard mode `ef_or`=1 (empty), `ff_ir`=0 (not full) and `dout`=0. In fall-through mode `ef_or`=0 (no data) and `ff_ir`=1 (ready for input).
- R2: A write is taken on a `wclk` edge only when `wen` and `wcs` are both 1. A read is taken on an `rclk` edge only when `ren` and `rcs` are both 1. A request with either select at 0 changes neither the stored data nor `dout`.
- R3: After DEPTH stored words with no reads, the full condition is set. In standard mode this is `ff_ir`=1; in fall-through mode it is `ff_ir`=0. Further writes are ignored until space is freed.
- R4: In standard mode a read loads the head slice into `dout` at the `rclk` edge that takes the read. `dout` holds that value until the next read.
- R5: In fall-through mode the head slice appears on `dout` with `ef_or`=1 and no read request. A read advances to the next slice or word.
- R6: Packing of narrow input into wide words fills the least significant slice first. `bus_cfg` 3 means 20-bit in and 40-bit out. `bus_cfg` 4 means 10-bit in and 40-bit out. Narrow input is taken from the low bits of `din`.
- R7: Unpacking of wide words into narrow output emits the least significant slice first. `bus_cfg` 1 means 40-bit in and 20-bit out. `bus_cfg` 2 means 40-bit in and 10-bit out. Narrow output appears in the low bits of `dout` with the upper bits at 0. `bus_cfg` 0 means 40-bit in and 40-bit out.
- R8: Raising `mark` records the word at the head of the read port. A one-cycle `rt` pulse while `mark` is held makes the next read return that word and the words after it again.
- R9: While `mark` is held, the free space is counted from the marked word. The full condition stays set after reads until `mark` is released.
- R10: Partial reset empties the buffer and keeps the latched width pairing and timing mode.
- R11: Changes on `bus_cfg` or `fwft_en` outside master reset have no effect.
- R12: Words leave in the order they were written, across the two clocks.

Ports are listed in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high. Hold it for at least 4 cycles of the slower clock. |
| prst | input | 1 | Partial reset, active high. Same hold rule as `mrst`. |
| bus_cfg | input | 3 | Width pairing, captured during master reset |
| fwft_en | input | 1 | 1 selects fall-through timing. Captured during master reset. |
| din | input | 40 | Write data. Narrow modes use the low bits. |
| wen | input | 1 | Write enable |
| wcs | input | 1 | Write chip select |
| ren | input | 1 | Read enable |
| rcs | input | 1 | Read chip select, sampled on `rclk` |
| mark | input | 1 | Level: records the head word on rising, protects it while high |
| rt | input | 1 | Retransmit request, acted on only while `mark` is high |
| dout | output | 40 | Read data |
| ef_or | output | 1 | Empty (standard) or output-ready (fall-through) |
| ff_ir | output | 1 | Full (standard) or input-ready (fall-through) |

## Verification
The bench builds the block with its defaults: 10-bit slices and a 64-word store, addressed by 6 bits. The bench runs a 125 MHz write clock against a slower, unrelated read clock. A 64-word depth makes it cheap to fill the store exactly and to push one write past full. Using all five width codes puts every packing and unpacking slice position within reach. Both timing modes and both reset levels are driven from the same bench. A mark held across a full store shows that the protected region survives reads and is released afterwards.

// File: rtl/wmfifo_pkg.sv
package wmfifo_pkg;

  typedef enum logic [2:0] {
    BW_W40_R40 = 3'd0,
    BW_W40_R20 = 3'd1,
    BW_W40_R10 = 3'd2,
    BW_W20_R40 = 3'd3,
    BW_W10_R40 = 3'd4
  } bus_cfg_e;

  // log2 of the number of input slices per stored word
  function automatic logic [1:0] in_lg(input logic [2:0] cfg);
    case (cfg)
      BW_W20_R40: in_lg = 2'd1;
      BW_W10_R40: in_lg = 2'd2;
      default:    in_lg = 2'd0;
    endcase
  endfunction

  // log2 of the number of output slices per stored word
  function automatic logic [1:0] out_lg(input logic [2:0] cfg);
    case (cfg)
      BW_W40_R20: out_lg = 2'd1;
      BW_W40_R10: out_lg = 2'd2;
      default:    out_lg = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/wmfifo_ptr_cdc.sv
module wmfifo_ptr_cdc #(
  parameter int PW = 7
) (
  input  logic          src_clk,
  input  logic          src_rst,
  input  logic [PW-1:0] src_bin,
  input  logic          dst_clk,
  input  logic          dst_rst,
  output logic [PW-1:0] dst_bin
);

  logic [PW-1:0] src_gray;
  logic [PW-1:0] meta_q;
  logic [PW-1:0] stab_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) src_gray <= '0;
    else         src_gray <= src_bin ^ (src_bin >> 1);
  end

  always_ff @(posedge dst_clk) begin
    if (dst_rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= src_gray;
      stab_q <= meta_q;
    end
  end

  always_comb begin
    for (int i = 0; i < PW; i++) dst_bin[i] = ^(stab_q >> i);
  end

  // R12: the crossing code moves by at most one bit per source clock
  a_r12_gray_one_bit: assert property (@(posedge src_clk) disable iff (src_rst)
    $onehot0(src_gray ^ $past(src_gray)));

endmodule

// File: rtl/wmfifo_ram.sv
module wmfifo_ram #(
  parameter int WW = 40,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/wmfifo_wr_ctrl.sv
module wmfifo_wr_ctrl
  import wmfifo_pkg::*;
#(
  parameter int SW = 10,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_m,
  input  logic             rst_p,
  input  logic [2:0]       cfg_i,
  input  logic             fwft_i,
  input  logic [4*SW-1:0]  din,
  input  logic             wen,
  input  logic             wcs,
  input  logic [AW:0]      free_bin,
  output logic [AW:0]      wr_bin,
  output logic             ram_we,
  output logic [AW-1:0]    ram_waddr,
  output logic [4*SW-1:0]  ram_wdata,
  output logic             ff_ir
);

  localparam int WW    = 4 * SW;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          rst;
  logic [1:0]    lg_q;
  logic          fwft_q;
  logic [WW-1:0] pack_q;
  logic [1:0]    pidx_q;
  logic [PW-1:0] wr_ptr;
  logic [WW-1:0] merged;
  logic          full;
  logic          accept;
  logic          last_slice;

  assign rst = rst_m | rst_p;

  always_ff @(posedge clk) begin
    if (rst_m) begin
      lg_q   <= in_lg(cfg_i);
      fwft_q <= fwft_i;
    end
  end

  assign full       = (wr_ptr - free_bin) == PW'(DEPTH);
  assign accept     = wen & wcs & ~full;
  assign last_slice = pidx_q == 2'((1 << lg_q) - 1);

  always_comb begin
    merged = pack_q;
    case (lg_q)
      2'd1:    merged[int'(pidx_q[0]) * (2*SW) +: 2*SW] = din[2*SW-1:0];
      2'd2:    merged[int'(pidx_q) * SW +: SW]         = din[SW-1:0];
      default: merged = din;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      pidx_q <= '0;
      pack_q <= '0;
    end else if (accept) begin
      if (last_slice) begin
        wr_ptr <= wr_ptr + PW'(1);
        pidx_q <= '0;
        pack_q <= '0;
      end else begin
        pidx_q <= pidx_q + 2'd1;
        pack_q <= merged;
      end
    end
  end

  assign ram_we    = accept & last_slice;
  assign ram_waddr = wr_ptr[AW-1:0];
  assign ram_wdata = merged;
  assign wr_bin    = wr_ptr;
  assign ff_ir     = fwft_q ? ~full : full;

  // R3: stored words never exceed the depth measured against the freed pointer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - free_bin) <= PW'(DEPTH));

  // R12: the write pointer advances by at most one word per clock
  a_r12_wptr_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_ptr == $past(wr_ptr)) || (wr_ptr == $past(wr_ptr) + PW'(1)));

  // R6: the slice index stays within the packing ratio
  a_r6_pidx_range: assert property (@(posedge clk) disable iff (rst)
    pidx_q <= 2'((1 << lg_q) - 1));

endmodule

// File: rtl/wmfifo_rd_ctrl.sv
module wmfifo_rd_ctrl
  import wmfifo_pkg::*;
#(
  parameter int SW = 10,
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             rst_m,
  input  logic             rst_p,
  input  logic [2:0]       cfg_i,
  input  logic             fwft_i,
  input  logic             ren,
  input  logic             rcs,
  input  logic             mark,
  input  logic             rt,
  input  logic [AW:0]      wr_bin,
  output logic             ram_re,
  output logic [AW-1:0]    ram_raddr,
  input  logic [4*SW-1:0]  ram_q,
  output logic [AW:0]      free_bin,
  output logic [4*SW-1:0]  dout,
  output logic             ef_or
);

  localparam int WW    = 4 * SW;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic          rst;
  logic [1:0]    lg_q;
  logic          fwft_q;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] free_ptr;
  logic [PW-1:0] mark_ptr;
  logic [PW-1:0] head;
  logic [PW-1:0] free_tgt;
  logic          mark_act;
  logic          hold_valid;
  logic [1:0]    sidx_q;
  logic [WW-1:0] dout_q;
  logic [WW-1:0] cur_slice;
  logic          avail;
  logic          last_slice;
  logic          consume;
  logic          do_rt;
  logic          fetch;

  assign rst = rst_m | rst_p;

  always_ff @(posedge clk) begin
    if (rst_m) begin
      lg_q   <= out_lg(cfg_i);
      fwft_q <= fwft_i;
    end
  end

  assign avail      = rd_ptr != wr_bin;
  assign last_slice = sidx_q == 2'((1 << lg_q) - 1);
  assign do_rt      = rt & mark_act;
  assign consume    = ren & rcs & hold_valid & ~do_rt;
  assign fetch      = ~do_rt & avail & (~hold_valid | (consume & last_slice));
  assign head       = hold_valid ? rd_ptr - PW'(1) : rd_ptr;
  assign free_tgt   = mark_act ? mark_ptr : head;

  always_comb begin
    cur_slice = '0;
    case (lg_q)
      2'd1:    cur_slice[2*SW-1:0] = ram_q[int'(sidx_q[0]) * (2*SW) +: 2*SW];
      2'd2:    cur_slice[SW-1:0]   = ram_q[int'(sidx_q) * SW +: SW];
      default: cur_slice = ram_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr     <= '0;
      hold_valid <= 1'b0;
      sidx_q     <= '0;
    end else if (do_rt) begin
      rd_ptr     <= mark_ptr;
      hold_valid <= 1'b0;
      sidx_q     <= '0;
    end else begin
      if (fetch) rd_ptr <= rd_ptr + PW'(1);
      if (consume) begin
        if (last_slice) begin
          sidx_q     <= '0;
          hold_valid <= fetch;
        end else begin
          sidx_q <= sidx_q + 2'd1;
        end
      end else if (fetch) begin
        hold_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    dout_q <= '0;
    else if (consume & ~fwft_q) dout_q <= cur_slice;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_act <= 1'b0;
      mark_ptr <= '0;
    end else if (!mark) begin
      mark_act <= 1'b0;
    end else if (!mark_act) begin
      mark_act <= 1'b1;
      mark_ptr <= head;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                        free_ptr <= '0;
    else if (free_ptr != free_tgt)  free_ptr <= free_ptr + PW'(1);
  end

  assign ram_re    = fetch;
  assign ram_raddr = rd_ptr[AW-1:0];
  assign free_bin  = free_ptr;
  assign dout      = fwft_q ? (hold_valid ? cur_slice : '0) : dout_q;
  assign ef_or     = fwft_q ? hold_valid : ~hold_valid;

  // R12: the read pointer never runs past the synchronized write pointer
  a_r12_no_underrun: assert property (@(posedge clk) disable iff (rst)
    (wr_bin - rd_ptr) <= PW'(DEPTH));

  // R9: the freed pointer never passes a held mark
  a_r9_mark_guard: assert property (@(posedge clk) disable iff (rst)
    mark_act |-> (mark_ptr - free_ptr) <= PW'(DEPTH));

  // R9: the freed pointer moves forward by one location at most per clock
  a_r9_free_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (free_ptr == $past(free_ptr)) || (free_ptr == $past(free_ptr) + PW'(1)));

  // R7: the output slice index stays within the unpacking ratio
  a_r7_sidx_range: assert property (@(posedge clk) disable iff (rst)
    sidx_q <= 2'((1 << lg_q) - 1));

  // R8: a retransmit empties the head register on the next clock
  a_r8_rt_reload: assert property (@(posedge clk) disable iff (rst)
    do_rt |=> !hold_valid);

endmodule

// File: rtl/wmfifo.sv
module wmfifo #(
  parameter int SW = 10,
  parameter int AW = 6
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             mrst,
  input  logic             prst,
  input  logic [2:0]       bus_cfg,
  input  logic             fwft_en,
  input  logic [4*SW-1:0]  din,
  input  logic             wen,
  input  logic             wcs,
  input  logic             ren,
  input  logic             rcs,
  input  logic             mark,
  input  logic             rt,
  output logic [4*SW-1:0]  dout,
  output logic             ef_or,
  output logic             ff_ir
);

  localparam int WW = 4 * SW;
  localparam int PW = AW + 1;

  logic          rst_any;
  logic [PW-1:0] wr_bin_w;
  logic [PW-1:0] wr_bin_r;
  logic [PW-1:0] free_bin_r;
  logic [PW-1:0] free_bin_w;
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [WW-1:0] ram_wdata;
  logic          ram_re;
  logic [AW-1:0] ram_raddr;
  logic [WW-1:0] ram_q;

  assign rst_any = mrst | prst;

  wmfifo_wr_ctrl #(.SW(SW), .AW(AW)) u_wr (
    .clk       (wclk),
    .rst_m     (mrst),
    .rst_p     (prst),
    .cfg_i     (bus_cfg),
    .fwft_i    (fwft_en),
    .din       (din),
    .wen       (wen),
    .wcs       (wcs),
    .free_bin  (free_bin_w),
    .wr_bin    (wr_bin_w),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ff_ir     (ff_ir)
  );

  wmfifo_ram #(.WW(WW), .AW(AW)) u_ram (
    .wclk  (wclk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .rclk  (rclk),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  wmfifo_ptr_cdc #(.PW(PW)) u_w2r (
    .src_clk (wclk),
    .src_rst (rst_any),
    .src_bin (wr_bin_w),
    .dst_clk (rclk),
    .dst_rst (rst_any),
    .dst_bin (wr_bin_r)
  );

  wmfifo_ptr_cdc #(.PW(PW)) u_r2w (
    .src_clk (rclk),
    .src_rst (rst_any),
    .src_bin (free_bin_r),
    .dst_clk (wclk),
    .dst_rst (rst_any),
    .dst_bin (free_bin_w)
  );

  wmfifo_rd_ctrl #(.SW(SW), .AW(AW)) u_rd (
    .clk       (rclk),
    .rst_m     (mrst),
    .rst_p     (prst),
    .cfg_i     (bus_cfg),
    .fwft_i    (fwft_en),
    .ren       (ren),
    .rcs       (rcs),
    .mark      (mark),
    .rt        (rt),
    .wr_bin    (wr_bin_r),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_q     (ram_q),
    .free_bin  (free_bin_r),
    .dout      (dout),
    .ef_or     (ef_or)
  );

endmodule

// File: tb/tb_wmfifo.sv
module tb_wmfifo;

  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        mrst = 1'b1;
  logic        prst = 1'b0;
  logic [2:0]  bus_cfg = 3'd0;
  logic        fwft_en = 1'b0;
  logic [39:0] din = '0;
  logic        wen = 1'b0;
  logic        wcs = 1'b0;
  logic        ren = 1'b0;
  logic        rcs = 1'b0;
  logic        mark = 1'b0;
  logic        rt = 1'b0;
  logic [39:0] dout;
  logic        ef_or;
  logic        ff_ir;

  int  n_chk  = 0;
  int  n_fail = 0;
  logic fwft_m = 1'b0;
  logic done = 1'b0;

  always #4 wclk = ~wclk;
  always #7 rclk = ~rclk;

  wmfifo dut (
    .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .bus_cfg(bus_cfg),
    .fwft_en(fwft_en), .din(din), .wen(wen), .wcs(wcs), .ren(ren), .rcs(rcs),
    .mark(mark), .rt(rt), .dout(dout), .ef_or(ef_or), .ff_ir(ff_ir)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_mrst(input logic [2:0] cfg, input logic ff);
    @(negedge rclk); #1;
    bus_cfg = cfg; fwft_en = ff; fwft_m = ff; mrst = 1'b1;
    repeat (4) @(negedge rclk);
    #1 mrst = 1'b0;
    repeat (2) @(negedge rclk);
  endtask

  task automatic do_prst();
    @(negedge rclk); #1 prst = 1'b1;
    repeat (4) @(negedge rclk);
    #1 prst = 1'b0;
    repeat (2) @(negedge rclk);
  endtask

  task automatic wr(input logic [39:0] v, input logic cs);
    @(negedge wclk);
    din = v; wen = 1'b1; wcs = cs;
    @(negedge wclk);
    wen = 1'b0; wcs = 1'b0;
  endtask

  task automatic rd(output logic [39:0] v);
    @(negedge rclk);
    for (int k = 0; k < 200 && (fwft_m ? !ef_or : ef_or); k++) @(negedge rclk);
    if (fwft_m) begin
      v = dout; ren = 1'b1; rcs = 1'b1;
      @(negedge rclk);
      ren = 1'b0; rcs = 1'b0;
    end else begin
      ren = 1'b1; rcs = 1'b1;
      @(negedge rclk);
      ren = 1'b0; rcs = 1'b0;
      v = dout;
    end
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  // R1: reset state in both timing modes
  task automatic t_reset();
    do_mrst(3'd0, 1'b0);
    check("R1 std empty", 64'(ef_or), 64'd1);
    check("R1 std not full", 64'(ff_ir), 64'd0);
    check("R1 std dout", 64'(dout), 64'd0);
    do_mrst(3'd0, 1'b1);
    check("R1 fwft no data", 64'(ef_or), 64'd0);
    check("R1 fwft input ready", 64'(ff_ir), 64'd1);
  endtask

  // R2, R4, R12: selects gate transfers, standard read timing, ordering
  task automatic t_basic();
    logic [39:0] v;
    do_mrst(3'd0, 1'b0);
    wr(40'h11_2233_4455, 1'b1);
    wr(40'hBB_BBBB_BBBB, 1'b0);
    wr(40'h66_7788_99AA, 1'b1);
    rd(v);
    check("R4 std read first", 64'(v), 64'h11_2233_4455);
    @(negedge rclk); ren = 1'b1; rcs = 1'b0;
    @(negedge rclk); ren = 1'b0;
    check("R2 read without rcs keeps dout", 64'(dout), 64'h11_2233_4455);
    rd(v);
    check("R12 second word order (wcs=0 write dropped)", 64'(v), 64'h66_7788_99AA);
    settle();
    check("R2 empty after two words", 64'(ef_or), 64'd1);
    check("R4 dout held after read", 64'(dout), 64'h66_7788_99AA);
  endtask

  // R3: fill to depth, extra write ignored
  task automatic t_full();
    logic [39:0] v;
    int bad;
    do_mrst(3'd0, 1'b0);
    for (int i = 0; i < 64; i++) wr(40'(i + 1000), 1'b1);
    @(negedge wclk);
    check("R3 full after 64 words", 64'(ff_ir), 64'd1);
    wr(40'hDE_ADDE_ADDE, 1'b1);
    bad = 0;
    for (int i = 0; i < 64; i++) begin
      rd(v);
      if (v !== 40'(i + 1000)) bad++;
    end
    check("R3 R12 drained words in order", 64'(bad), 64'd0);
    settle();
    check("R3 write while full ignored", 64'(ef_or), 64'd1);
    @(negedge wclk);
    check("R3 full cleared after drain", 64'(ff_ir), 64'd0);
  endtask

  // R6: packing narrow to wide, least significant slice first
  task automatic t_pack();
    logic [39:0] v;
    do_mrst(3'd4, 1'b0);
    wr(40'h000_0000_0A1, 1'b1);
    wr(40'h000_0000_0B2, 1'b1);
    wr(40'h000_0000_0C3, 1'b1);
    settle();
    check("R6 partial word not visible", 64'(ef_or), 64'd1);
    wr(40'h000_0000_0D4, 1'b1);
    rd(v);
    check("R6 10-bit pack", 64'(v), 64'({10'h0D4, 10'h0C3, 10'h0B2, 10'h0A1}));
    do_mrst(3'd3, 1'b0);
    wr(40'h00_0001_2345, 1'b1);
    wr(40'h00_0006_789A, 1'b1);
    rd(v);
    check("R6 20-bit pack", 64'(v), 64'({20'h6789A, 20'h12345}));
  endtask

  // R7, R11: unpacking wide to narrow, configuration pins ignored after reset
  task automatic t_unpack();
    logic [39:0] v;
    logic [39:0] w;
    w = {10'h3A1, 10'h2B2, 10'h1C3, 10'h0D4};
    do_mrst(3'd2, 1'b0);
    bus_cfg = 3'd0;
    fwft_en = 1'b1;
    wr(w, 1'b1);
    for (int i = 0; i < 4; i++) begin
      rd(v);
      check("R7 R11 10-bit slice", 64'(v), 64'(w[i*10 +: 10]));
    end
    do_mrst(3'd1, 1'b0);
    wr(40'hAB_CDEF_0123, 1'b1);
    rd(v);
    check("R7 20-bit low half", 64'(v), 64'h0_F0123);
    rd(v);
    check("R7 20-bit high half", 64'(v), 64'h0_ABCDE);
  endtask

  // R10: partial reset clears data and keeps the width pairing
  task automatic t_prst();
    logic [39:0] v;
    logic [39:0] w;
    w = {10'h111, 10'h222, 10'h333, 10'h044};
    do_mrst(3'd2, 1'b0);
    wr(40'h12_3456_789A, 1'b1);
    settle();
    do_prst();
    settle();
    check("R10 empty after partial reset", 64'(ef_or), 64'd1);
    wr(w, 1'b1);
    rd(v);
    check("R10 pairing kept slice0", 64'(v), 64'(w[9:0]));
    rd(v);
    check("R10 pairing kept slice1", 64'(v), 64'(w[19:10]));
  endtask

  // R8: mark then retransmit
  task automatic t_mark();
    logic [39:0] v;
    do_mrst(3'd0, 1'b0);
    for (int i = 0; i < 4; i++) wr(40'(100 + i), 1'b1);
    rd(v);
    check("R8 pre-mark read", 64'(v), 64'd100);
    @(negedge rclk); mark = 1'b1;
    @(negedge rclk);
    rd(v); rd(v);
    check("R8 read past mark", 64'(v), 64'd102);
    @(negedge rclk); rt = 1'b1;
    @(negedge rclk); rt = 1'b0;
    rd(v);
    check("R8 retransmit returns marked word", 64'(v), 64'd101);
    rd(v);
    check("R8 retransmit continues", 64'(v), 64'd102);
    rd(v);
    check("R8 retransmit reaches tail", 64'(v), 64'd103);
    @(negedge rclk); mark = 1'b0;
  endtask

  // R9: held mark keeps space reserved; R5 fall-through first-word timing
  task automatic t_mark_cap();
    logic [39:0] v;
    do_mrst(3'd0, 1'b0);
    @(negedge rclk); mark = 1'b1;
    @(negedge rclk);
    for (int i = 0; i < 64; i++) wr(40'(i), 1'b1);
    for (int i = 0; i < 10; i++) rd(v);
    check("R9 reads under mark", 64'(v), 64'd9);
    settle();
    @(negedge wclk);
    check("R9 full held by mark", 64'(ff_ir), 64'd1);
    @(negedge rclk); mark = 1'b0;
    settle();
    @(negedge wclk);
    check("R9 full released with mark", 64'(ff_ir), 64'd0);
  endtask

  task automatic t_fwft();
    logic [39:0] v;
    do_mrst(3'd0, 1'b1);
    wr(40'h00_0000_0055, 1'b1);
    settle();
    check("R5 output ready without read", 64'(ef_or), 64'd1);
    check("R5 head word presented", 64'(dout), 64'h55);
    wr(40'h00_0000_0066, 1'b1);
    rd(v);
    check("R5 first fall-through read", 64'(v), 64'h55);
    rd(v);
    check("R5 second fall-through read", 64'(v), 64'h66);
    settle();
    check("R5 not ready when drained", 64'(ef_or), 64'd0);
    do_mrst(3'd1, 1'b1);
    wr(40'h98_7654_3210, 1'b1);
    rd(v);
    check("R5 R7 fall-through low half", 64'(v), 64'h0_43210);
    rd(v);
    check("R5 R7 fall-through high half", 64'(v), 64'h0_98765);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_full();
    t_pack();
    t_unpack();
    t_prst();
    t_mark();
    t_mark_cap();
    t_fwft();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule